// File: doc/BRIEF.md
# Dual-Rail Delay-Insensitive 2:1 Multiplexer

This block selects between two dual-rail data words under a dual-rail select. Each signal uses a pair of rails. A signal is either a data value or an all-zero spacer, and it must return to the spacer between data values. The datapath is three dual-rail NAND stages per bit. Each stage is built from two-input hysteresis elements, with an OR over three of them forming the true rail. The first two NAND stages form the two select terms, and the second of these takes the select with its rails swapped. The third NAND stage merges the two terms.

The hysteresis elements are modelled as clocked registers. A data wavefront or a spacer wavefront therefore reaches the output two clock edges after the inputs. The output does not move until every input on its path has arrived. This makes each output transition an acknowledgement of its inputs.

A completion stage reports three conditions:
- every output bit holds data;
- the output has fully returned to the spacer;
- a forbidden code has appeared on any input or output rail pair. This flag is sticky.

Top module: `ncl_dr_mux`

## Requirements
- R1: Each signal is a rail pair (t,f). Logical 1 is t=1,f=0. Logical 0 is t=0,f=1. The spacer is t=0,f=0. The pair t=1,f=1 is forbidden.
- R2: Each hysteresis element sets when all its inputs are 1 and clears when all are 0. It keeps its value for any other input pattern, and reset clears it.
- R3: While any input (select, any a bit, any b bit) is still a spacer, the output stays a spacer. It never changes to data earlier than two clock edges after the last input became data.
- R4: Two clock edges after all inputs hold data, each z bit equals the a bit when select is 1 and the b bit when select is 0.
- R5: Two clock edges after all inputs return to the spacer, every z bit is the spacer.
- R6: done_o is 1 exactly when every z bit has one rail high. null_o is 1 exactly when every z rail is 0.
- R7: err_o becomes 1 on the clock edge after any input or output pair shows the forbidden code. It stays 1 until reset.
- R8: After reset, z is the spacer, done_o=0, null_o=1 and err_o=0.
- R9: Returning the select alone to the spacer while a and b still hold data leaves z at its data value. z returns to the spacer only after a and b also do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock that samples the hysteresis state |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_t_i | input | 1 | Select true rail |
| sel_f_i | input | 1 | Select false rail |
| a_t_i | input | WIDTH | Data a true rails |
| a_f_i | input | WIDTH | Data a false rails |
| b_t_i | input | WIDTH | Data b true rails |
| b_f_i | input | WIDTH | Data b false rails |
| z_t_o | output | WIDTH | Result true rails |
| z_f_o | output | WIDTH | Result false rails |
| done_o | output | 1 | All result bits hold data |
| null_o | output | 1 | All result rails are 0 |
| err_o | output | 1 | Sticky forbidden-code flag |

## Verification
The assertions are checked on every cycle. They cover:
- the set, clear and hold behaviour of every hysteresis element;
- the output leaving the spacer only after a complete input set two edges earlier;
- the error flag being raised and then staying raised.

Only the bench scenarios can show that the selected value is correct for all eight select and data combinations. The same holds for the spacer return, and for the hold seen when only the select drops back to the spacer. For those cases the expected word depends on the stimulus history rather than on a single-cycle relation.

// File: rtl/ncl_mux_pkg.sv
package ncl_mux_pkg;
  typedef struct packed {
    logic t;
    logic f;
  } dr_t;

  localparam dr_t DR_SPACER = '{t: 1'b0, f: 1'b0};

  function automatic logic dr_has_data(dr_t v);
    return v.t ^ v.f;
  endfunction

  function automatic logic dr_is_bad(dr_t v);
    return v.t & v.f;
  endfunction

  // inversion is a rail swap
  function automatic dr_t dr_inv(dr_t v);
    return '{t: v.f, f: v.t};
  endfunction
endpackage

// File: rtl/ncl_c_elem.sv
module ncl_c_elem #(
  parameter int unsigned N_IN = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_IN-1:0] in_i,
  output logic            q_o
);
  logic all_hi, all_lo;

  assign all_hi = &in_i;
  assign all_lo = ~|in_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (all_hi) q_o <= 1'b1;
    else if (all_lo) q_o <= 1'b0;
  end

  p_c_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&in_i) |=> q_o);
  p_c_clr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (~|in_i) |=> !q_o);
  p_c_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(&in_i) && (|in_i)) |=> $stable(q_o));
endmodule

// File: rtl/ncl_dr_nand.sv
module ncl_dr_nand
  import ncl_mux_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  dr_t  a_i,
  input  dr_t  b_i,
  output dr_t  y_o
);
  localparam int unsigned N_TERMS = 4;

  logic [1:0]         pair [N_TERMS];
  logic [N_TERMS-1:0] term;

  // term 0 drives the false rail; terms 1..3 are ORed into the true rail
  assign pair[0] = {a_i.t, b_i.t};
  assign pair[1] = {a_i.f, b_i.f};
  assign pair[2] = {a_i.f, b_i.t};
  assign pair[3] = {a_i.t, b_i.f};

  for (genvar g = 0; g < N_TERMS; g++) begin : g_term
    ncl_c_elem #(.N_IN(2)) u_c (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .in_i  (pair[g]),
      .q_o   (term[g])
    );
  end

  assign y_o.f = term[0];
  assign y_o.t = |term[N_TERMS-1:1];
endmodule

// File: rtl/ncl_completion.sv
module ncl_completion #(
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned N_WATCH = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [WIDTH-1:0]   z_t_i,
  input  logic [WIDTH-1:0]   z_f_i,
  input  logic [N_WATCH-1:0] w_t_i,
  input  logic [N_WATCH-1:0] w_f_i,
  output logic               done_o,
  output logic               null_o,
  output logic               err_o
);
  logic any_bad;

  assign done_o  = &(z_t_i ^ z_f_i);
  assign null_o  = ~|(z_t_i | z_f_i);
  assign any_bad = |(w_t_i & w_f_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      err_o <= 1'b0;
    else if (any_bad) err_o <= 1'b1;
  end

  p_err_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

// File: rtl/ncl_dr_mux.sv
module ncl_dr_mux
  import ncl_mux_pkg::*;
#(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_t_i,
  input  logic             sel_f_i,
  input  logic [WIDTH-1:0] a_t_i,
  input  logic [WIDTH-1:0] a_f_i,
  input  logic [WIDTH-1:0] b_t_i,
  input  logic [WIDTH-1:0] b_f_i,
  output logic [WIDTH-1:0] z_t_o,
  output logic [WIDTH-1:0] z_f_o,
  output logic             done_o,
  output logic             null_o,
  output logic             err_o
);
  // watched pairs: select, a bits, b bits, z bits
  localparam int unsigned N_WATCH = 1 + 3 * WIDTH;

  dr_t s_d, s_n;
  assign s_d = '{t: sel_t_i, f: sel_f_i};
  assign s_n = dr_inv(s_d);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    dr_t a_d, b_d, x_d, y_d, z_d;
    assign a_d = '{t: a_t_i[i], f: a_f_i[i]};
    assign b_d = '{t: b_t_i[i], f: b_f_i[i]};

    ncl_dr_nand u_x (.clk_i(clk_i), .rst_ni(rst_ni), .a_i(s_d), .b_i(a_d), .y_o(x_d));
    ncl_dr_nand u_y (.clk_i(clk_i), .rst_ni(rst_ni), .a_i(s_n), .b_i(b_d), .y_o(y_d));
    ncl_dr_nand u_z (.clk_i(clk_i), .rst_ni(rst_ni), .a_i(x_d), .b_i(y_d), .y_o(z_d));

    assign z_t_o[i] = z_d.t;
    assign z_f_o[i] = z_d.f;
  end

  logic [N_WATCH-1:0] w_t, w_f;
  assign w_t = {sel_t_i, a_t_i, b_t_i, z_t_o};
  assign w_f = {sel_f_i, a_f_i, b_f_i, z_f_o};

  ncl_completion #(.WIDTH(WIDTH), .N_WATCH(N_WATCH)) u_cmp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .z_t_i (z_t_o),
    .z_f_i (z_f_o),
    .w_t_i (w_t),
    .w_f_i (w_f),
    .done_o(done_o),
    .null_o(null_o),
    .err_o (err_o)
  );

  logic in_full;
  assign in_full = dr_has_data(s_d) & (&(a_t_i ^ a_f_i)) & (&(b_t_i ^ b_f_i));

  p_z_needs_full_in_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(null_o) |-> $past(in_full, 2));
  p_err_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(w_t & w_f)) |=> err_o);
endmodule

// File: tb/ncl_dr_mux_tb.sv
module ncl_dr_mux_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sel_t, sel_f;
  logic [0:0] a_t, a_f, b_t, b_f, z_t, z_f;
  logic done, nul, err;
  int checks = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ncl_dr_mux #(.WIDTH(1)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .sel_t_i(sel_t), .sel_f_i(sel_f),
    .a_t_i(a_t), .a_f_i(a_f), .b_t_i(b_t), .b_f_i(b_f),
    .z_t_o(z_t), .z_f_o(z_f),
    .done_o(done), .null_o(nul), .err_o(err)
  );

  // {s, a, b, expected z}
  localparam logic [3:0] VEC [8] = '{
    4'b0000, 4'b0011, 4'b0100, 4'b0111,
    4'b1000, 4'b1010, 4'b1101, 4'b1111
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic drive_all_null();
    sel_t = 0; sel_f = 0; a_t = 0; a_f = 0; b_t = 0; b_f = 0;
  endtask

  task automatic drive_data(input logic s, input logic a, input logic b);
    sel_t = s; sel_f = ~s; a_t = a; a_f = ~a; b_t = b; b_f = ~b;
  endtask

  initial begin
    drive_all_null();
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 z_t", z_t, 0); chk("R8 z_f", z_f, 0);
    chk("R8 done", done, 0); chk("R8 null", nul, 1); chk("R8 err", err, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 R4 R5 R6: table walk
    for (int k = 0; k < 8; k++) begin
      drive_data(VEC[k][3], VEC[k][2], VEC[k][1]);
      @(negedge clk);
      chk("R3 z still spacer after one edge", {z_t, z_f}, 2'b00);
      @(negedge clk);
      chk("R4 z value", {z_t, z_f}, {VEC[k][0], ~VEC[k][0]});
      chk("R6 done", {done, nul}, 2'b10);
      drive_all_null();
      @(negedge clk);
      chk("R2 z holds one edge into spacer", {z_t, z_f}, {VEC[k][0], ~VEC[k][0]});
      @(negedge clk);
      chk("R5 z spacer", {z_t, z_f}, 2'b00);
      chk("R6 null", {done, nul}, 2'b01);
    end

    // R3: partial data, b missing, z must stay spacer
    sel_t = 1; sel_f = 0; a_t = 1; a_f = 0; b_t = 0; b_f = 0;
    repeat (4) @(negedge clk);
    chk("R3 partial input keeps spacer", {z_t, z_f}, 2'b00);
    b_f = 1;
    @(negedge clk);
    chk("R3 one edge after b arrives", {z_t, z_f}, 2'b00);
    @(negedge clk);
    chk("R4 z=a after late b", {z_t, z_f}, 2'b10);

    // R9: only select returns to spacer, z holds
    sel_t = 0; sel_f = 0;
    repeat (4) @(negedge clk);
    chk("R9 z holds with select spacer", {z_t, z_f}, 2'b10);
    chk("R9 done holds", done, 1);
    a_t = 0; b_f = 0;
    repeat (2) @(negedge clk);
    chk("R9 z spacer after all spacer", {z_t, z_f}, 2'b00);

    // R7: forbidden code on select
    chk("R7 err clear before", err, 0);
    sel_t = 1; sel_f = 1;
    @(negedge clk);
    chk("R7 err set", err, 1);
    drive_all_null();
    repeat (4) @(negedge clk);
    chk("R7 err sticky", err, 1);
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R8 err cleared by reset", err, 0);
    chk("R8 null after reset", nul, 1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      checks++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule